// File: doc/BRIEF.md
# Wait-State Wake-Up and Reset Cause Controller

This block decides how a small processor system leaves its low-power wait state. Several sources can end the wait. They are an asynchronous external reset, a clock-loss pulse from an oscillator monitor, a watchdog expiry pulse, and a set of generic interrupt requests, each with its own enable. A small configuration register sets how clock loss is handled. One bit arms the monitor. A second bit chooses between fallback self-clocking and a hard reset. A third bit decides whether the self-clock event may wake the core. The fourth bit selects the PLL as the system clock.

A reset is requested with a two-bit cause code that the core uses to pick its vector. The code holds for a fixed 64-cycle sequence and is still valid in the cycle of the one-cycle vector-fetch strobe. A self-clock event instead sets an interrupt flag, enters self-clock mode and strobes the clock-quality checker. The checker reports success through a handshake input. An interrupt taken while the PLL is powered down drops the PLL select, so the system wakes on the oscillator clock.

There is no data stream through this block. Every pin is a plain level or a single-cycle pulse, with no back-pressure.

Top module: `wait_wake_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `rst_req` is 1 and `rst_cause` is 2'b01 without waiting for a clock edge. `cfg_q` returns to its default 4'b0010, and `wake`, `scm_flag` and `scm_active` are 0. Release passes through a two-flop synchronizer, and `vec_fetch` pulses in the 66th cycle after release.
- R2: An internal reset holds `rst_req` high for exactly 64 cycles and is followed by a one-cycle `vec_fetch`. `rst_cause` keeps its value through the strobe cycle and reads 2'b00 from the next cycle on.
- R3: With the monitor-enable bit (`cfg_q[0]`) at 0, a `mon_fail` pulse causes no reset, no wake and no self-clock activity.
- R4: A `mon_fail` pulse with monitor enable 1 and self-clock enable (`cfg_q[1]`) 0 starts a reset with cause 2'b10 and restores `cfg_q` to its default.
- R5: A `mon_fail` pulse with monitor enable 1, self-clock enable 1 and self-clock wake enable (`cfg_q[2]`) 1 sets `scm_flag` and `scm_active` and pulses `qc_start` one cycle later. It also pulses `wake` when `in_wait` is 1, and only then.
- R6: The same event with self-clock wake enable 0 sets `scm_flag` and `scm_active` and pulses `qc_start`, but it does not raise `wake`. An enabled interrupt in the same cycle still wakes the core.
- R7: In wait, any `irq_req` bit whose `irq_en` bit is 1 gives a one-cycle `wake` pulse one cycle later. Disabled requests, and requests outside wait, give no wake.
- R8: When a wake occurs while `pll_off` is 1, `pll_sel` (`cfg_q[3]`) is cleared and stays 0 until software writes it back to 1. A self-clock event that does not wake the core leaves `pll_sel` unchanged.
- R9: `scm_active` and `pll_keep_on` stay high, whether or not the core is in wait, until a `qc_pass` pulse clears them. A quality pass gives no wake.
- R10: A `wdog_rst` pulse starts a reset with cause 2'b11.
- R11: When sources arrive in the same cycle, the order is: clock-monitor reset, then watchdog reset, then the self-clock event, then interrupts. A reset suppresses every wake and every self-clock effect.
- R12: While the reset sequence runs, `mon_fail`, `wdog_rst` and interrupts are ignored. The cause code does not change, and no wake is produced.
- R13: `cfg_wr` loads `cfg_wdata` into `cfg_q` with the bits ordered {pll_sel, self-clock wake enable, self-clock enable, monitor enable}, MSB first. The write is ignored while `rst_req` is 1.
- R14: `irq_ack` clears `scm_flag`. A self-clock event in the same cycle wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assertion |
| in_wait | input | 1 | Core is in the wait state |
| mon_fail | input | 1 | Clock-loss pulse from the oscillator monitor |
| wdog_rst | input | 1 | Watchdog expiry pulse |
| irq_req | input | N_IRQ | Generic interrupt requests |
| irq_en | input | N_IRQ | Per-request enables |
| pll_off | input | 1 | PLL is powered down |
| qc_pass | input | 1 | Clock-quality check succeeded |
| irq_ack | input | 1 | Clears the self-clock interrupt flag |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data |
| rst_req | output | 1 | Reset sequence in progress |
| rst_cause | output | 2 | 00 none, 01 external, 10 clock monitor, 11 watchdog |
| vec_fetch | output | 1 | One-cycle strobe at the end of the reset sequence |
| wake | output | 1 | One-cycle wake pulse |
| scm_flag | output | 1 | Self-clock interrupt flag |
| scm_active | output | 1 | Self-clock mode active |
| qc_start | output | 1 | One-cycle start strobe for the quality checker |
| pll_keep_on | output | 1 | PLL and regulator must stay powered |
| pll_sel | output | 1 | System clock from PLL (1) or oscillator (0) |
| cfg_q | output | 4 | Current configuration register |

## Verification
Every synchronous result has the same latency. A stimulus driven before clock edge T shows up as `wake`, `qc_start`, `scm_flag`, `scm_active`, `pll_sel`, `rst_req` or `rst_cause` right after T. The bench therefore drives on a falling edge and compares on the next falling edge.

Two results follow other timing. The external-reset outputs change with no edge at all, so the bench samples them one nanosecond after it drives `ext_rst_n` low. The end of a reset is counted in cycles: 64 samples with `rst_req` high after an internal trigger, and `vec_fetch` on the 66th edge after external release. These counts come from the bench's own loops, not from any internal counter.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_EXT    = 2'b01,
    CAUSE_CLKMON = 2'b10,
    CAUSE_WDOG   = 2'b11
  } cause_e;

  // Field order is the software-visible bit order, MSB first.
  typedef struct packed {
    logic pll_sel;
    logic scm_ie;
    logic scm_en;
    logic mon_en;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{pll_sel: 1'b0, scm_ie: 1'b0, scm_en: 1'b1, mon_en: 1'b0};

  typedef struct packed {
    logic   go_reset;
    cause_e cause;
    logic   scm_evt;
    logic   wake_now;
  } arb_t;

endpackage

// File: rtl/wake_rst_sync.sv
module wake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh;

  // Assert immediately, release only after STAGES clean edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh[STAGES-1];
endmodule

// File: rtl/wake_src_arb.sv
module wake_src_arb
  import wake_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             seq_busy,
  input  cfg_t             cfg,
  input  logic             in_wait,
  input  logic             mon_fail,
  input  logic             wdog_rst,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output arb_t             dec
);
  logic cm_hit;
  logic irq_hit;

  assign cm_hit  = mon_fail & cfg.mon_en;
  assign irq_hit = |(irq_req & irq_en);

  // Fixed priority: monitor reset, watchdog reset, self-clock event, interrupts.
  always_comb begin
    dec       = '0;
    dec.cause = CAUSE_NONE;
    if (!seq_busy) begin
      if (cm_hit && !cfg.scm_en) begin
        dec.go_reset = 1'b1;
        dec.cause    = CAUSE_CLKMON;
      end else if (wdog_rst) begin
        dec.go_reset = 1'b1;
        dec.cause    = CAUSE_WDOG;
      end else begin
        dec.scm_evt  = cm_hit;
        dec.wake_now = in_wait & ((cm_hit & cfg.scm_ie) | irq_hit);
      end
    end
  end
endmodule

// File: rtl/wake_rst_seq.sv
module wake_rst_seq
  import wake_pkg::*;
#(
  parameter int SEQ_CYCLES = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trig,
  input  cause_e trig_cause,
  output logic   busy,
  output cause_e cause,
  output logic   vec_fetch
);
  localparam int CW = (SEQ_CYCLES > 1) ? $clog2(SEQ_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEQ_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      cnt       <= '0;
      cause     <= CAUSE_EXT;
      vec_fetch <= 1'b0;
    end else begin
      vec_fetch <= 1'b0;
      if (busy) begin
        if (cnt == LAST) begin
          busy      <= 1'b0;
          vec_fetch <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        // The cause stays valid through the strobe cycle and is cleared afterwards.
        if (vec_fetch) cause <= CAUSE_NONE;
        if (trig) begin
          busy  <= 1'b1;
          cnt   <= '0;
          cause <= trig_cause;
        end
      end
    end
  end
endmodule

// File: rtl/wake_clk_state.sv
module wake_clk_state
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic in_reset,
  input  logic cfg_wr,
  input  cfg_t cfg_wdata,
  input  logic scm_evt,
  input  logic wake_now,
  input  logic pll_off,
  input  logic qc_pass,
  input  logic irq_ack,
  output cfg_t cfg_q,
  output logic scm_flag,
  output logic scm_active,
  output logic qc_start,
  output logic wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_DEFAULT;
    end else if (soft_rst) begin
      cfg_q <= CFG_DEFAULT;
    end else begin
      if (cfg_wr && !in_reset) cfg_q <= cfg_wdata;
      // Waking with the PLL down forces the oscillator clock, overriding a write.
      if (wake_now && pll_off) cfg_q.pll_sel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scm_flag   <= 1'b0;
      scm_active <= 1'b0;
      qc_start   <= 1'b0;
      wake       <= 1'b0;
    end else if (soft_rst) begin
      scm_flag   <= 1'b0;
      scm_active <= 1'b0;
      qc_start   <= 1'b0;
      wake       <= 1'b0;
    end else begin
      qc_start <= scm_evt;
      wake     <= wake_now;
      if (scm_evt)      scm_active <= 1'b1;
      else if (qc_pass) scm_active <= 1'b0;
      if (scm_evt)      scm_flag <= 1'b1;
      else if (irq_ack) scm_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wait_wake_ctrl.sv
module wait_wake_ctrl
  import wake_pkg::*;
#(
  parameter int N_IRQ      = 4,
  parameter int SEQ_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             ext_rst_n,
  input  logic             in_wait,
  input  logic             mon_fail,
  input  logic             wdog_rst,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             pll_off,
  input  logic             qc_pass,
  input  logic             irq_ack,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_wdata,
  output logic             rst_req,
  output logic [1:0]       rst_cause,
  output logic             vec_fetch,
  output logic             wake,
  output logic             scm_flag,
  output logic             scm_active,
  output logic             qc_start,
  output logic             pll_keep_on,
  output logic             pll_sel,
  output logic [3:0]       cfg_q
);
  logic   rst_n_s;
  arb_t   dec;
  cfg_t   cfg_r;
  cause_e cause_r;
  logic   busy;

  wake_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (ext_rst_n),
    .rst_n_s (rst_n_s)
  );

  wake_src_arb #(.N_IRQ(N_IRQ)) u_arb (
    .seq_busy (busy),
    .cfg      (cfg_r),
    .in_wait  (in_wait),
    .mon_fail (mon_fail),
    .wdog_rst (wdog_rst),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .dec      (dec)
  );

  wake_rst_seq #(.SEQ_CYCLES(SEQ_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .trig       (dec.go_reset),
    .trig_cause (dec.cause),
    .busy       (busy),
    .cause      (cause_r),
    .vec_fetch  (vec_fetch)
  );

  wake_clk_state u_state (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .soft_rst   (dec.go_reset),
    .in_reset   (busy),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_t'(cfg_wdata)),
    .scm_evt    (dec.scm_evt),
    .wake_now   (dec.wake_now),
    .pll_off    (pll_off),
    .qc_pass    (qc_pass),
    .irq_ack    (irq_ack),
    .cfg_q      (cfg_r),
    .scm_flag   (scm_flag),
    .scm_active (scm_active),
    .qc_start   (qc_start),
    .wake       (wake)
  );

  assign rst_req     = busy;
  assign rst_cause   = cause_r;
  assign cfg_q       = cfg_r;
  assign pll_sel     = cfg_r.pll_sel;
  assign pll_keep_on = scm_active;
endmodule

// File: rtl/wait_wake_ctrl_chk.sv
module wait_wake_ctrl_chk (
  input logic       clk,
  input logic       ext_rst_n,
  input logic       mon_fail,
  input logic       wdog_rst,
  input logic       pll_off,
  input logic       rst_req,
  input logic [1:0] rst_cause,
  input logic       vec_fetch,
  input logic       wake,
  input logic       scm_flag,
  input logic       scm_active,
  input logic       qc_start,
  input logic [3:0] cfg_q
);
  p_cause_held_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (rst_req && $past(rst_req)) |-> $stable(rst_cause));

  p_cause_clear_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (!rst_req && !vec_fetch) |-> (rst_cause == 2'b00));

  p_strobe_end_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    vec_fetch |-> ($past(rst_req) && !rst_req));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    vec_fetch |=> !vec_fetch);

  p_mon_ignored_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (mon_fail && !cfg_q[0] && !wdog_rst && !rst_req) |=> (!rst_req && !qc_start));

  p_cfg_default_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (rst_req && !$past(rst_req)) |-> (cfg_q == 4'b0010));

  p_qc_in_scm_r5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    qc_start |-> (scm_active && scm_flag));

  p_pll_drop_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wake && $past(pll_off)) |-> !cfg_q[3]);

  p_reset_no_wake_r11: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_req |-> (!wake && !qc_start));
endmodule

bind wait_wake_ctrl wait_wake_ctrl_chk u_chk (
  .clk        (clk),
  .ext_rst_n  (ext_rst_n),
  .mon_fail   (mon_fail),
  .wdog_rst   (wdog_rst),
  .pll_off    (pll_off),
  .rst_req    (rst_req),
  .rst_cause  (rst_cause),
  .vec_fetch  (vec_fetch),
  .wake       (wake),
  .scm_flag   (scm_flag),
  .scm_active (scm_active),
  .qc_start   (qc_start),
  .cfg_q      (cfg_q)
);

// File: tb/wait_wake_ctrl_tb.sv
`timescale 1ns/1ps
module wait_wake_ctrl_tb;
  localparam int N_IRQ = 4;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic in_wait = 0, mon_fail = 0, wdog_rst = 0, pll_off = 0, qc_pass = 0, irq_ack = 0, cfg_wr = 0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic [3:0] cfg_wdata = '0;
  logic rst_req, vec_fetch, wake, scm_flag, scm_active, qc_start, pll_keep_on, pll_sel;
  logic [1:0] rst_cause;
  logic [3:0] cfg_q;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wait_wake_ctrl #(.N_IRQ(N_IRQ)) u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .in_wait(in_wait), .mon_fail(mon_fail),
    .wdog_rst(wdog_rst), .irq_req(irq_req), .irq_en(irq_en), .pll_off(pll_off),
    .qc_pass(qc_pass), .irq_ack(irq_ack), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rst_req(rst_req), .rst_cause(rst_cause), .vec_fetch(vec_fetch), .wake(wake),
    .scm_flag(scm_flag), .scm_active(scm_active), .qc_start(qc_start),
    .pll_keep_on(pll_keep_on), .pll_sel(pll_sel), .cfg_q(cfg_q)
  );

  // {cfg, wait, mon, wdog, irq_req, irq_en, pll_off, e_rst, e_cause, e_wake, e_flag, e_act, e_qc, e_pll, 2'b00}
  localparam logic [25:0] VEC [NV] = '{
    {4'b1011,1'b1,1'b0,1'b0,4'b0001,4'b0001,1'b1, 1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b1011,1'b1,1'b0,1'b0,4'b0001,4'b0000,1'b1, 1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00},
    {4'b1011,1'b0,1'b0,1'b0,4'b0001,4'b0001,1'b1, 1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00},
    {4'b0000,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b0, 1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b1001,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b0, 1'b1,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b0111,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b0, 1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00},
    {4'b0011,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b0, 1'b0,2'b00,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00},
    {4'b0011,1'b1,1'b1,1'b0,4'b0010,4'b0010,1'b0, 1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00},
    {4'b0000,1'b0,1'b0,1'b1,4'b0000,4'b0000,1'b0, 1'b1,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b0001,1'b0,1'b1,1'b1,4'b0000,4'b0000,1'b0, 1'b1,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b0111,1'b1,1'b1,1'b1,4'b0000,4'b0000,1'b0, 1'b1,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b1000,1'b1,1'b0,1'b1,4'b0100,4'b0100,1'b0, 1'b1,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00},
    {4'b1111,1'b0,1'b1,1'b0,4'b0000,4'b0000,1'b0, 1'b0,2'b00,1'b0,1'b1,1'b1,1'b1,1'b1,2'b00},
    {4'b1011,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b1, 1'b0,2'b00,1'b0,1'b1,1'b1,1'b1,1'b1,2'b00}
  };
  string VTAG [NV] = '{"R7 R8", "R7", "R7", "R3", "R4", "R5", "R6", "R6", "R10",
                       "R11", "R11", "R11", "R5", "R8"};

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    in_wait = 0; mon_fail = 0; wdog_rst = 0; pll_off = 0; qc_pass = 0;
    irq_ack = 0; cfg_wr = 0; irq_req = '0; irq_en = '0;
  endtask

  task automatic settle();
    qc_pass = 1; irq_ack = 1;
    tick();
    qc_pass = 0; irq_ack = 0;
    for (int k = 0; k < 200 && rst_req === 1'b1; k++) tick();
    tick();
  endtask

  task automatic write_cfg(logic [3:0] v);
    cfg_wr = 1; cfg_wdata = v;
    tick();
    cfg_wr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    int hi;
    // R1: state while the external reset is held
    repeat (3) tick();
    chk("R1", "rst_req", rst_req, 1);
    chk("R1", "cause", rst_cause, 2'b01);
    chk("R1", "cfg_q", cfg_q, 4'b0010);
    chk("R1", "wake", wake, 0);
    chk("R1", "scm_flag", scm_flag, 0);
    // R1/R2: release timing and cause retention
    ext_rst_n = 1;
    n = 0;
    do begin tick(); n++; end while (vec_fetch !== 1'b1 && n < 200);
    chk("R1", "edges to vec_fetch", n, 66);
    chk("R2", "cause at strobe", rst_cause, 2'b01);
    tick();
    chk("R2", "cause after strobe", rst_cause, 2'b00);
    chk("R2", "rst_req after strobe", rst_req, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [25:0] e;
      e = VEC[v];
      write_cfg(e[25:22]);
      in_wait = e[21]; mon_fail = e[20]; wdog_rst = e[19];
      irq_req = e[18:15]; irq_en = e[14:11]; pll_off = e[10];
      tick();
      clear_in();
      chk(VTAG[v], "rst_req", rst_req, e[9]);
      chk(VTAG[v], "cause", rst_cause, e[8:7]);
      chk(VTAG[v], "wake", wake, e[6]);
      chk(VTAG[v], "scm_flag", scm_flag, e[5]);
      chk(VTAG[v], "scm_active", scm_active, e[4]);
      chk(VTAG[v], "qc_start", qc_start, e[3]);
      chk(VTAG[v], "pll_sel", pll_sel, e[2]);
      settle();
    end

    // R2, R12, R13: internal sequence length, with traffic ignored during it
    wdog_rst = 1;
    tick();
    wdog_rst = 0;
    cfg_wr = 1; cfg_wdata = 4'b1111; in_wait = 1; irq_req = 4'b0001; irq_en = 4'b0001; mon_fail = 1;
    hi = 0;
    while (rst_req === 1'b1 && hi < 300) begin
      hi++;
      tick();
      if (hi == 1) begin
        clear_in();
        chk("R12", "cause during seq", rst_cause, 2'b11);
        chk("R12", "wake during seq", wake, 0);
        chk("R13", "cfg write in reset", cfg_q, 4'b0010);
      end
    end
    chk("R2", "rst_req cycles", hi, 64);
    chk("R2", "vec_fetch", vec_fetch, 1);
    chk("R10", "cause at strobe", rst_cause, 2'b11);
    tick();

    // R1: asynchronous assertion in the middle of a sequence
    wdog_rst = 1; tick(); wdog_rst = 0;
    repeat (5) tick();
    #2 ext_rst_n = 0;
    #1;
    chk("R1", "async cause", rst_cause, 2'b01);
    chk("R1", "async rst_req", rst_req, 1);
    tick();
    ext_rst_n = 1;
    settle();

    // R8, R13: PLL select stays cleared until rewritten
    write_cfg(4'b1000);
    chk("R13", "cfg write", cfg_q, 4'b1000);
    in_wait = 1; irq_req = 4'b1000; irq_en = 4'b1000; pll_off = 1;
    tick();
    clear_in();
    chk("R8", "pll cleared", pll_sel, 0);
    repeat (5) tick();
    chk("R8", "pll still cleared", pll_sel, 0);
    write_cfg(4'b1000);
    chk("R8", "pll rewritten", pll_sel, 1);

    // R9: self-clock mode persists through wait until a quality pass
    write_cfg(4'b0011);
    in_wait = 1; mon_fail = 1;
    tick();
    mon_fail = 0;
    repeat (8) tick();
    chk("R9", "scm_active held", scm_active, 1);
    chk("R9", "keep_on held", pll_keep_on, 1);
    chk("R9", "no wake", wake, 0);
    qc_pass = 1;
    tick();
    qc_pass = 0;
    chk("R9", "scm_active cleared", scm_active, 0);
    chk("R9", "keep_on cleared", pll_keep_on, 0);
    chk("R9", "no wake on pass", wake, 0);

    // R14: acknowledge against a simultaneous event
    chk("R14", "flag before ack", scm_flag, 1);
    irq_ack = 1; mon_fail = 1;
    tick();
    mon_fail = 0;
    chk("R14", "set wins", scm_flag, 1);
    tick();
    irq_ack = 0;
    chk("R14", "ack clears", scm_flag, 0);
    clear_in();
    settle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule